// File: doc/BRIEF.md
# Multiplexed External Memory Bus Controller

This controller performs single reads and writes to external data memory over a narrow multiplexed bus. The 16-bit address is split in two. The upper byte goes out on a dedicated output port. The lower byte shares an 8-bit bidirectional bus with the data. An address latch strobe tells an external latch when to capture the low byte. The bus then turns over: it carries write data, or it is released so that memory can drive read data. Separate active-low read and write strobes select the direction.

Timing is counted in CPU cycles. In normal mode one CPU cycle is two oscillator clocks. In fast mode it is one oscillator clock. A stretch control widens the read/write strobe from 3 to 15 CPU cycles, for slow peripherals. The address phase is the same in both cases. The internal side uses a request/acknowledge handshake. The request is accepted only when the controller is idle, and a one-clock completion pulse returns the read data.

Top module: `xmem_bus_ctrl`

## Requirements
- R1: While `rst` is high and after its release, `rd_n` and `wr_n` are 1, `ale`, `ad_oe` and `done` are 0.
- R2: During an access `addr_hi` shows address bits 15:8. `ale` is high for exactly the first CPU cycle, while `ad_oe`=1 and `ad_out` carries address bits 7:0.
- R3: The low address stays driven on `ad_out` from the start of the access until the strobe asserts. `ale` falls one CPU cycle before the strobe, and the strobe is never low while `ale` is high.
- R4: An unstretched access lasts 6 CPU cycles and a stretched one 18. A CPU cycle is 2 oscillator clocks when `cfg_x2`=0 and 1 when `cfg_x2`=1. The count runs from the clock after acceptance to the clock before `done`.
- R5: The active strobe stays low for 3 CPU cycles when `cfg_stretch`=0 and for 15 when it is 1.
- R6: Only one strobe asserts per access: `rd_n` when `req_we`=0, `wr_n` when `req_we`=1.
- R7: On a write, `ad_out` carries the write data with `ad_oe`=1 for the whole time `wr_n` is low and for one oscillator clock after it rises. It is released on the next clock.
- R8: On a read, `ad_oe` is 0 while `rd_n` is low. `ad_in` is sampled on the last oscillator clock before `rd_n` rises, and that value appears on `rdata` with `done`.
- R9: `req_ack` is high exactly when `req` is high and the controller is idle. A request made while busy is ignored and starts no access.
- R10: `done` is a single-clock pulse at the end of every access.
- R11: `cfg_stretch`, `cfg_x2`, the address, data and direction are captured when the request is accepted. Changes to them during an access do not alter that access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Access request |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 8 | Write data |
| cfg_stretch | input | 1 | 1 = long strobe (15 CPU cycles) |
| cfg_x2 | input | 1 | 1 = one oscillator clock per CPU cycle |
| req_ack | output | 1 | Request accepted this clock |
| done | output | 1 | One-clock completion pulse |
| rdata | output | 8 | Read data, valid with `done` |
| addr_hi | output | 8 | Upper address byte port |
| ale | output | 1 | Address latch enable |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |
| ad_out | output | 8 | Shared bus, outgoing value |
| ad_oe | output | 1 | Shared bus output enable |
| ad_in | input | 8 | Shared bus, incoming value |

## Verification
The bench's memory model drives valid read data only during the final oscillator clock of the read strobe. A controller that samples early or late therefore returns the filler value and not the addressed byte. Write-data hold is checked on the clock after `wr_n` rises. The release is checked on the clock after that, so a controller that drops the data with the strobe, or keeps the bus driven, is caught. All four combinations of stretch and fast mode are timed. One access has its request, configuration and direction toggled partway through. A design that re-reads its inputs would change length there, or would start a second access after `done`.

// File: rtl/xmem_bus_ctrl.sv
module xmem_bus_ctrl #(
  parameter int DW        = 8,
  parameter int AW        = 16,
  parameter int SETUP_CYC = 2,
  parameter int SHORT_W   = 3,
  parameter int LONG_W    = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          cfg_stretch,
  input  logic          cfg_x2,
  output logic          req_ack,
  output logic          done,
  output logic [DW-1:0] rdata,
  output logic [AW-DW-1:0] addr_hi,
  output logic          ale,
  output logic          rd_n,
  output logic          wr_n,
  output logic [DW-1:0] ad_out,
  output logic          ad_oe,
  input  logic [DW-1:0] ad_in
);

  localparam int CW = $clog2(SETUP_CYC + LONG_W + 2);
  localparam int SW = $clog2(2 * LONG_W + 2) + 1;

  logic          busy, sub;
  logic [CW-1:0] cyc;
  logic          lat_we, lat_long, lat_x2;
  logic [AW-1:0] lat_addr;
  logic [DW-1:0] lat_wdata;

  logic [CW-1:0] strb_last, cyc_last;
  logic          cpu_end, addr_ph, in_strobe;

  assign strb_last = lat_long ? CW'(SETUP_CYC + LONG_W - 1) : CW'(SETUP_CYC + SHORT_W - 1);
  assign cyc_last  = strb_last + CW'(1);
  assign cpu_end   = lat_x2 | sub;
  assign addr_ph   = busy && (cyc < CW'(SETUP_CYC));
  assign in_strobe = busy && (cyc >= CW'(SETUP_CYC)) && (cyc <= strb_last);

  assign req_ack = req && !busy;
  assign ale     = busy && (cyc == '0);
  assign rd_n    = !(in_strobe && !lat_we);
  assign wr_n    = !(in_strobe && lat_we);
  assign addr_hi = lat_addr[AW-1:DW];
  assign ad_out  = addr_ph ? lat_addr[DW-1:0] : lat_wdata;
  assign ad_oe   = addr_ph ||
                   (busy && lat_we && (in_strobe || (cyc == cyc_last && !sub)));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy      <= 1'b0;
      sub       <= 1'b0;
      cyc       <= '0;
      lat_we    <= 1'b0;
      lat_long  <= 1'b0;
      lat_x2    <= 1'b0;
      lat_addr  <= '0;
      lat_wdata <= '0;
      done      <= 1'b0;
      rdata     <= '0;
    end else begin
      done <= 1'b0;
      if (req_ack) begin
        busy      <= 1'b1;
        sub       <= 1'b0;
        cyc       <= '0;
        lat_we    <= req_we;
        lat_long  <= cfg_stretch;
        lat_x2    <= cfg_x2;
        lat_addr  <= req_addr;
        lat_wdata <= req_wdata;
      end else if (busy) begin
        if (cpu_end) begin
          sub <= 1'b0;
          if (cyc == strb_last && !lat_we) rdata <= ad_in;
          if (cyc == cyc_last) begin
            busy <= 1'b0;
            done <= 1'b1;
          end else begin
            cyc <= cyc + CW'(1);
          end
        end else begin
          sub <= 1'b1;
        end
      end
    end
  end

  // strobe-width watch: counts oscillator clocks with a strobe low
  logic [SW-1:0] low_cnt, low_exp;
  always_ff @(posedge clk) begin
    if (rst) low_cnt <= '0;
    else if (!rd_n || !wr_n) low_cnt <= low_cnt + SW'(1);
    else low_cnt <= '0;
  end
  assign low_exp = SW'((lat_long ? LONG_W : SHORT_W) * (lat_x2 ? 1 : 2));

  assert_strobe_width_R5: assert property (@(posedge clk) disable iff (rst)
    ($rose(rd_n) || $rose(wr_n)) |-> (low_cnt == low_exp));

  assert_single_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    !(!rd_n && !wr_n));

  assert_ale_before_strobe_R3: assert property (@(posedge clk) disable iff (rst)
    (!rd_n || !wr_n) |-> !ale);

  assert_addr_after_ale_R3: assert property (@(posedge clk) disable iff (rst)
    $fell(ale) |-> ad_oe);

  assert_write_hold_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_n) |-> ad_oe);

  assert_read_release_R8: assert property (@(posedge clk) disable iff (rst)
    !rd_n |-> !ad_oe);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_ack_starts_R9: assert property (@(posedge clk) disable iff (rst)
    req_ack |=> ale);

endmodule

// File: tb/sim_xmem_bus_ctrl.sv
module sim_xmem_bus_ctrl;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic        req = 0, req_we = 0, cfg_stretch = 0, cfg_x2 = 0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ack, done, ale, rd_n, wr_n, ad_oe;
  logic [7:0]  rdata, addr_hi, ad_out, ad_in;

  int checks = 0, fails = 0;
  int rd_cnt = 0, rd_last = 0;
  logic [15:0] cur_addr = '0;

  function automatic logic [7:0] model(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction

  assign ad_in = (!rd_n && rd_cnt == rd_last) ? model(cur_addr) : 8'hC3;
  always @(posedge clk) rd_cnt <= rd_n ? 0 : rd_cnt + 1;

  xmem_bus_ctrl u0 (
    .clk(clk), .rst(rst), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .cfg_stretch(cfg_stretch), .cfg_x2(cfg_x2),
    .req_ack(req_ack), .done(done), .rdata(rdata), .addr_hi(addr_hi),
    .ale(ale), .rd_n(rd_n), .wr_n(wr_n), .ad_out(ad_out), .ad_oe(ad_oe),
    .ad_in(ad_in)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic we, input logic lng, input logic x2,
                     input logic [15:0] a, input logic [7:0] wd, input bit disturb);
    int k, w, n, ale_c, st_c, hold_at;
    bit prev_lo, lo, seen, bad_hi, bad_st, bad_seq, bad_wd, bad_oe, bad_ack;
    logic [7:0] lat;
    k = x2 ? 1 : 2; w = lng ? 15 : 3;
    n = 0; ale_c = 0; st_c = 0; hold_at = -1; lat = '0;
    prev_lo = 0; seen = 0; bad_hi = 0; bad_st = 0; bad_seq = 0;
    bad_wd = 0; bad_oe = 0; bad_ack = 0;
    rd_last = w * k - 1; cur_addr = a;
    @(negedge clk);
    req = 1; req_we = we; cfg_stretch = lng; cfg_x2 = x2; req_addr = a; req_wdata = wd;
    #1 chk(req_ack == 1'b1, "R9 ack while idle", int'(req_ack), 1);
    @(negedge clk);
    req = 0;
    while (!done && n < 100) begin
      n++;
      lo = !rd_n || !wr_n;
      if (addr_hi != a[15:8]) bad_hi = 1;
      if (ale) begin
        ale_c++; lat = ad_out;
        if (!ad_oe || seen) bad_seq = 1;
      end
      if (!seen && !lo && (!ad_oe || ad_out != a[7:0])) bad_seq = 1;
      if (lo) begin
        st_c++; seen = 1;
        if (ale) bad_seq = 1;
        if (we) begin
          if (!rd_n) bad_st = 1;
          if (!ad_oe || ad_out != wd) bad_wd = 1;
        end else begin
          if (!wr_n) bad_st = 1;
          if (ad_oe) bad_oe = 1;
        end
      end
      if (we && prev_lo && !lo) begin
        chk(ad_oe && ad_out == wd, "R7 data held after wr_n rise", int'(ad_out), int'(wd));
        hold_at = n;
      end
      if (hold_at >= 0 && n == hold_at + 1)
        chk(!ad_oe, "R7 bus released", int'(ad_oe), 0);
      if (disturb && n == 3) begin
        req = 1; req_we = ~we; cfg_stretch = ~lng; cfg_x2 = ~x2;
        req_addr = ~a; req_wdata = ~wd;
      end
      if (disturb && n >= 3) begin
        #1 if (req_ack) bad_ack = 1;
      end
      prev_lo = lo;
      @(negedge clk);
    end
    if (disturb) req = 0;
    if (hold_at >= 0 && hold_at == n) chk(!ad_oe, "R7 bus released", int'(ad_oe), 0);
    chk(done == 1'b1, "R10 done reached", int'(done), 1);
    chk(n == (3 + w) * k, disturb ? "R11 length fixed at start" : "R4 access length", n, (3 + w) * k);
    chk(ale_c == k, "R2 ale width", ale_c, k);
    chk(lat == a[7:0], "R2 latched low address", int'(lat), int'(a[7:0]));
    chk(!bad_hi, "R2 high address port", int'(addr_hi), int'(a[15:8]));
    chk(st_c == w * k, "R5 strobe width", st_c, w * k);
    chk(!bad_st, "R6 single correct strobe", int'(bad_st), 0);
    chk(!bad_seq, "R3 address then strobe order", int'(bad_seq), 0);
    if (we) chk(!bad_wd, "R7 data during wr_n low", int'(bad_wd), 0);
    else begin
      chk(!bad_oe, "R8 bus off during rd_n", int'(bad_oe), 0);
      chk(rdata == model(a), "R8 read data last clock", int'(rdata), int'(model(a)));
    end
    if (disturb) chk(!bad_ack, "R9 no ack while busy", int'(bad_ack), 0);
    @(negedge clk);
    chk(!done, "R10 done one clock", int'(done), 0);
    if (disturb) begin
      for (int i = 0; i < 3; i++) begin
        chk(!ale && rd_n && wr_n, "R9 ignored request starts nothing", int'(ale), 0);
        @(negedge clk);
      end
    end
  endtask

  localparam logic [26:0] VEC [8] = '{
    {1'b0, 1'b0, 1'b0, 16'h12A5, 8'h00},
    {1'b1, 1'b0, 1'b0, 16'h3400, 8'h96},
    {1'b0, 1'b0, 1'b1, 16'hFF01, 8'h00},
    {1'b1, 1'b0, 1'b1, 16'h00FF, 8'h3C},
    {1'b0, 1'b1, 1'b0, 16'hABCD, 8'h00},
    {1'b1, 1'b1, 1'b0, 16'h8001, 8'hE7},
    {1'b0, 1'b1, 1'b1, 16'h5A5A, 8'h00},
    {1'b1, 1'b1, 1'b1, 16'hC0DE, 8'h01}
  };

  initial begin
    #2000000;
    fails++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rd_n && wr_n && !ale && !ad_oe && !done, "R1 state in reset", int'({rd_n, wr_n, ale, ad_oe, done}), 5'b11000);
    rst = 0;
    @(negedge clk);
    chk(rd_n && wr_n && !ale && !ad_oe && !done, "R1 idle after reset", int'({rd_n, wr_n, ale, ad_oe, done}), 5'b11000);
    for (int i = 0; i < 8; i++) begin
      logic [26:0] v;
      v = VEC[i];
      run(v[26], v[25], v[24], v[23:8], v[7:0], 1'b0);
    end
    run(1'b0, 1'b0, 1'b0, 16'h4321, 8'h00, 1'b1);
    run(1'b1, 1'b1, 1'b1, 16'h7E81, 8'hA5, 1'b1);
    run(1'b0, 1'b1, 1'b0, 16'h0000, 8'h00, 1'b1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule